// File: doc/BRIEF.md
# Per-Master Aperture Address Remapper

This block rewrites the 32-bit request address of each of several bus masters before the request enters a multi-slave interconnect. The address space is cut into sixteen 256 MB windows, picked by the top four address bits. For each window and each master, a small table names the target slave and the window number to use on that slave. The block outputs the target slave index and the rewritten address. A window whose slave index is zero is reported as unmapped instead of being routed.

Each master has its own table. Software programs the table through a 32-bit configuration bus into staging (shadow) registers, with the nibbles packed eight to a word. It then writes a one-hot or multi-bit mask to a shared commit register. Only at that commit does a master's live table change, and it changes in a single clock edge. Translation is combinational from the live table, followed by one output register.

Top module: `aperture_remapper`

## Requirements
- R1: The window of a request is `req_addr[31:28]`. One cycle after a valid request, the response carries the window's slave index and the address `{offset, req_addr[27:0]}`.
- R2: In bank word 0 bits [4a+3:4a] hold the slave index of window a (a = 0..7). Word 1 (byte +0x4) holds windows 8..15 in the same way. Word 2 (+0x8) and word 3 (+0xC) hold the offsets.
- R3: A window whose live slave index is 0 gives `rsp_unmapped_o` = 1, `rsp_slave_o` = 0, and the request address passed through unchanged.
- R4: Writes to shadow words do not change translation until a commit for that master.
- R5: Writing mask bit m to the commit register at `UPD_OFFSET` (default 0x100) copies master m's shadow words into its live table. Masters whose bit is 0 keep their live table.
- R6: The bank of master m starts at byte address 16·m. The banks are independent.
- R7: After reset every shadow and live entry is zero, so every window of every master is unmapped.
- R8: A read of a bank word returns the shadow value. A read of the commit register returns 0.
- R9: A request presented in the same cycle as a commit write is translated with the old table. The next cycle's request uses the new table.
- R10: `rsp_valid_o[m]` follows `req_valid_i[m]` one cycle later. `rsp_unmapped_o[m]` is never 1 without `rsp_valid_o[m]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration byte address |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data, combinational from cfg_addr_i |
| req_valid_i | input | N_MST | Request valid per master |
| req_addr_i | input | N_MST x 32 | Request address per master |
| rsp_valid_o | output | N_MST | Registered valid per master |
| rsp_unmapped_o | output | N_MST | Window has no target |
| rsp_slave_o | output | N_MST x 4 | Target slave index |
| rsp_addr_o | output | N_MST x 32 | Rewritten address |

## Verification
The bench builds the block with three masters. This keeps every window of every master within reach of a full sweep: 48 translations for each table state. With three masters, the bench can commit a single master, commit a multi-bit mask, and leave a master untouched, all in one run. Table contents come from arithmetic functions of the master and window numbers. They deliberately include zero slave indices, so mapped and unmapped windows sit next to each other in every sweep. The bench also places a commit write and a request in the same cycle to expose the old-table/new-table boundary.

// File: rtl/ap_remap_pkg.sv
package ap_remap_pkg;
  localparam int ADDR_W = 32;
  localparam int NIB_W  = 4;
  localparam int APT_N  = 16;
  localparam int LOW_W  = ADDR_W - NIB_W;
  localparam int HALF_N = APT_N / 2;

  typedef logic [APT_N-1:0][NIB_W-1:0] nib_map_t;
endpackage

// File: rtl/ap_remap_cfg.sv
module ap_remap_cfg
  import ap_remap_pkg::*;
#(
  parameter int               N_MST      = 10,
  parameter int               CFG_AW     = 12,
  parameter logic [CFG_AW-1:0] UPD_OFFSET = CFG_AW'('h100)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [31:0]             cfg_wdata_i,
  output logic [31:0]             cfg_rdata_o,
  output logic [N_MST-1:0]        upd_o,
  output nib_map_t [N_MST-1:0]    shd_sel_o,
  output nib_map_t [N_MST-1:0]    shd_off_o,
  output nib_map_t [N_MST-1:0]    act_sel_o,
  output nib_map_t [N_MST-1:0]    act_off_o
);
  localparam int BANK_W = CFG_AW - 4;

  logic [BANK_W-1:0] bank;
  logic [1:0]        word;
  logic              aligned;
  logic              upd_hit;

  assign bank    = cfg_addr_i[CFG_AW-1:4];
  assign word    = cfg_addr_i[3:2];
  assign aligned = (cfg_addr_i[1:0] == 2'b00);
  assign upd_hit = cfg_we_i && (cfg_addr_i == UPD_OFFSET);

  for (genvar m = 0; m < N_MST; m++) begin : g_bank
    nib_map_t s_sel, s_off, a_sel, a_off;
    logic     hit;

    assign hit      = aligned && (bank == BANK_W'(m));
    assign upd_o[m] = upd_hit && cfg_wdata_i[m];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_sel <= '0;
        s_off <= '0;
      end else if (cfg_we_i && hit) begin
        case (word)
          2'd0: s_sel[HALF_N-1:0]     <= cfg_wdata_i;
          2'd1: s_sel[APT_N-1:HALF_N] <= cfg_wdata_i;
          2'd2: s_off[HALF_N-1:0]     <= cfg_wdata_i;
          default: s_off[APT_N-1:HALF_N] <= cfg_wdata_i;
        endcase
      end
    end

    // live table swaps whole on the commit edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_sel <= '0;
        a_off <= '0;
      end else if (upd_o[m]) begin
        a_sel <= s_sel;
        a_off <= s_off;
      end
    end

    assign shd_sel_o[m] = s_sel;
    assign shd_off_o[m] = s_off;
    assign act_sel_o[m] = a_sel;
    assign act_off_o[m] = a_off;
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int m = 0; m < N_MST; m++) begin
      if (aligned && (bank == BANK_W'(m))) begin
        case (word)
          2'd0: cfg_rdata_o = shd_sel_o[m][HALF_N-1:0];
          2'd1: cfg_rdata_o = shd_sel_o[m][APT_N-1:HALF_N];
          2'd2: cfg_rdata_o = shd_off_o[m][HALF_N-1:0];
          default: cfg_rdata_o = shd_off_o[m][APT_N-1:HALF_N];
        endcase
      end
    end
  end
endmodule

// File: rtl/ap_remap_xlate.sv
module ap_remap_xlate
  import ap_remap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  nib_map_t          act_sel_i,
  input  nib_map_t          act_off_i,
  output logic              rsp_valid_o,
  output logic              rsp_unmapped_o,
  output logic [NIB_W-1:0]  rsp_slave_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  logic [NIB_W-1:0]  idx, sel, off;
  logic              none;
  logic [ADDR_W-1:0] nxt_addr;

  assign idx      = req_addr_i[ADDR_W-1:LOW_W];
  assign sel      = act_sel_i[idx];
  assign off      = act_off_i[idx];
  assign none     = (sel == '0);
  assign nxt_addr = none ? req_addr_i : {off, req_addr_i[LOW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_unmapped_o <= 1'b0;
      rsp_slave_o    <= '0;
      rsp_addr_o     <= '0;
    end else begin
      rsp_valid_o    <= req_valid_i;
      rsp_unmapped_o <= req_valid_i && none;
      rsp_slave_o    <= sel;
      rsp_addr_o     <= nxt_addr;
    end
  end
endmodule

// File: rtl/aperture_remapper.sv
module aperture_remapper
  import ap_remap_pkg::*;
#(
  parameter int                N_MST      = 10,
  parameter int                CFG_AW     = 12,
  parameter logic [CFG_AW-1:0] UPD_OFFSET = CFG_AW'('h100)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [CFG_AW-1:0]             cfg_addr_i,
  input  logic [31:0]                   cfg_wdata_i,
  output logic [31:0]                   cfg_rdata_o,
  input  logic [N_MST-1:0]              req_valid_i,
  input  logic [N_MST-1:0][ADDR_W-1:0]  req_addr_i,
  output logic [N_MST-1:0]              rsp_valid_o,
  output logic [N_MST-1:0]              rsp_unmapped_o,
  output logic [N_MST-1:0][NIB_W-1:0]   rsp_slave_o,
  output logic [N_MST-1:0][ADDR_W-1:0]  rsp_addr_o
);
  logic [N_MST-1:0]     upd_vec;
  nib_map_t [N_MST-1:0] shd_sel, shd_off, act_sel, act_off;

  ap_remap_cfg #(
    .N_MST(N_MST), .CFG_AW(CFG_AW), .UPD_OFFSET(UPD_OFFSET)
  ) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .upd_o(upd_vec),
    .shd_sel_o(shd_sel), .shd_off_o(shd_off),
    .act_sel_o(act_sel), .act_off_o(act_off)
  );

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    ap_remap_xlate u_xlate (
      .clk_i, .rst_ni,
      .req_valid_i   (req_valid_i[m]),
      .req_addr_i    (req_addr_i[m]),
      .act_sel_i     (act_sel[m]),
      .act_off_i     (act_off[m]),
      .rsp_valid_o   (rsp_valid_o[m]),
      .rsp_unmapped_o(rsp_unmapped_o[m]),
      .rsp_slave_o   (rsp_slave_o[m]),
      .rsp_addr_o    (rsp_addr_o[m])
    );
  end
endmodule

// File: rtl/ap_remap_checker.sv
module ap_remap_checker
  import ap_remap_pkg::*;
#(
  parameter int N_MST = 10
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_MST-1:0]              req_valid_i,
  input logic [N_MST-1:0][ADDR_W-1:0]  req_addr_i,
  input logic [N_MST-1:0]              rsp_valid_o,
  input logic [N_MST-1:0]              rsp_unmapped_o,
  input logic [N_MST-1:0][NIB_W-1:0]   rsp_slave_o,
  input logic [N_MST-1:0][ADDR_W-1:0]  rsp_addr_o,
  input logic [N_MST-1:0]              upd_vec,
  input nib_map_t [N_MST-1:0]          shd_sel,
  input nib_map_t [N_MST-1:0]          shd_off,
  input nib_map_t [N_MST-1:0]          act_sel,
  input nib_map_t [N_MST-1:0]          act_off
);
  for (genvar m = 0; m < N_MST; m++) begin : g_chk
    p_valid_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i[m] |=> rsp_valid_o[m]);
    p_valid_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i[m] |=> !rsp_valid_o[m]);
    p_unmapped_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_unmapped_o[m] |-> rsp_valid_o[m]);
    p_unmapped_slave_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_unmapped_o[m] |-> (rsp_slave_o[m] == '0));
    p_low_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i[m] |=> (rsp_addr_o[m][LOW_W-1:0] == $past(req_addr_i[m][LOW_W-1:0])));
    p_hold_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_vec[m] |=> ($stable(act_sel[m]) && $stable(act_off[m])));
    p_commit_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_vec[m] |=> ((act_sel[m] == $past(shd_sel[m])) && (act_off[m] == $past(shd_off[m]))));
  end
endmodule

bind aperture_remapper ap_remap_checker #(.N_MST(N_MST)) u_chk (.*);

// File: tb/aperture_remapper_test.sv
`timescale 1ns/1ps
module aperture_remapper_test;
  localparam int N = 3;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [N-1:0] req_valid = '0;
  logic [N-1:0][31:0] req_addr = '0;
  logic [N-1:0] rsp_valid, rsp_unmapped;
  logic [N-1:0][3:0] rsp_slave;
  logic [N-1:0][31:0] rsp_addr;

  int n_run = 0, n_fail = 0;
  int ssel[N][16], soff[N][16], asel[N][16], aoff[N][16];

  always #2.5 clk = ~clk;

  aperture_remapper #(.N_MST(N), .CFG_AW(AW), .UPD_OFFSET(12'h100)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_unmapped_o(rsp_unmapped),
    .rsp_slave_o(rsp_slave), .rsp_addr_o(rsp_addr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int m, input int a);
    logic [31:0] v;
    v = 32'(a) * 32'h0123_4571 + 32'(m) * 32'h00AB_CDE1;
    return {4'(a), v[27:0]};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [31:0] pack(input int m, input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++)
      v[4*i +: 4] = (w < 2) ? 4'(ssel[m][8*w + i]) : 4'(soff[m][8*(w-2) + i]);
    return v;
  endfunction

  task automatic program_bank(input int m);
    for (int w = 0; w < 4; w++) wr(AW'(16*m + 4*w), pack(m, w));
  endtask

  task automatic commit_model(input int mask);
    for (int m = 0; m < N; m++)
      if (mask[m]) for (int a = 0; a < 16; a++) begin
        asel[m][a] = ssel[m][a]; aoff[m][a] = soff[m][a];
      end
  endtask

  task automatic check_rsp(input int m, input int a, input string tag);
    logic [31:0] in, ea;
    int s;
    in = mk_addr(m, a);
    s = asel[m][a];
    ea = (s == 0) ? in : {4'(aoff[m][a]), in[27:0]};
    check(rsp_valid[m] === 1'b1, {tag, " valid"}, 32'(rsp_valid[m]), 1);
    check(rsp_unmapped[m] === (s == 0), {tag, " unmapped"}, 32'(rsp_unmapped[m]), 32'(s == 0));
    check(rsp_slave[m] === 4'(s), {tag, " slave"}, 32'(rsp_slave[m]), 32'(s));
    check(rsp_addr[m] === ea, {tag, " addr"}, rsp_addr[m], ea);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      for (int m = 0; m < N; m++) req_addr[m] = mk_addr(m, a);
      req_valid = '1;
      @(negedge clk);
      req_valid = '0;
      for (int m = 0; m < N; m++) check_rsp(m, a, tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int m = 0; m < N; m++) for (int a = 0; a < 16; a++) begin
      ssel[m][a] = 0; soff[m][a] = 0; asel[m][a] = 0; aoff[m][a] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: reset state
    for (int w = 0; w < 4; w++) begin
      rd(AW'(4*w), d);
      check(d === 32'h0, "R7 reset shadow read", d, 0);
    end
    sweep("R7 reset unmapped");

    // load shadow maps; R6 bank spacing 16 bytes
    for (int m = 0; m < N; m++) begin
      for (int a = 0; a < 16; a++) begin
        ssel[m][a] = ((a + m) % 4 == 0) ? 0 : ((a * 3 + m) % 15) + 1;
        soff[m][a] = (a * 7 + m * 3 + 1) % 16;
      end
      program_bank(m);
    end
    sweep("R4 shadow without commit");

    // R2/R8: readback of packed shadow words and commit register
    for (int m = 0; m < N; m++) for (int w = 0; w < 4; w++) begin
      rd(AW'(16*m + 4*w), d);
      check(d === pack(m, w), "R2 R8 R6 shadow readback", d, pack(m, w));
    end
    rd(12'h100, d);
    check(d === 32'h0, "R8 commit reads zero", d, 0);

    // R5: commit master 1 only
    wr(12'h100, 32'h2);
    commit_model(2);
    sweep("R5 single commit");

    // R5: multi-bit mask
    wr(12'h100, 32'h5);
    commit_model(5);
    sweep("R1 R3 full map");

    // R9: commit and request in the same cycle
    for (int a = 0; a < 16; a++) soff[0][a] = soff[0][a] ^ 10;
    wr(12'h008, pack(0, 2));
    wr(12'h00C, pack(0, 3));
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 12'h100; cfg_wdata = 32'h1;
    req_addr[0] = mk_addr(0, 5); req_valid = 3'b001;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = '0;
    check_rsp(0, 5, "R9 same-cycle old map");
    commit_model(1);
    @(negedge clk);
    req_addr[0] = mk_addr(0, 5); req_valid = 3'b001;
    @(negedge clk);
    req_valid = '0;
    check_rsp(0, 5, "R9 next-cycle new map");

    // R10: idle request
    @(negedge clk);
    check(rsp_valid === '0, "R10 idle valid", 32'(rsp_valid), 0);
    check(rsp_unmapped === '0, "R10 idle unmapped", 32'(rsp_unmapped), 0);

    sweep("R1 final map");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule